// File: doc/BRIEF.md
# Block-Transfer Configuration Register Slave

This block is a two-wire serial slave that holds a small bank of 8-bit configuration registers and presents all of them as one parallel output vector. Both bus lines are sampled with a fast system clock, passed through synchronizers and a glitch filter, and decoded into START and STOP conditions and clock edges. The slave answers to the 7-bit address 69h. The write form of the address byte is D2h and the read form is D3h.

Only whole-bank transfers are supported. No register pointer exists. A write carries a command byte and a count byte, which the slave acknowledges and discards. The data bytes that follow fill the registers from index 0 upwards. A read returns a count byte followed by the registers in ascending order. The host may end either transfer with a STOP after any complete byte. The slave drives SDA only as an open-drain pull-down enable, and it changes that enable only while SCL is low.

Top module: `blkcfg_i2c_slave`

## Requirements
- R1: Address byte D2h (write) or D3h (read) is acknowledged. Any other address byte is not acknowledged, and the rest of that transfer changes no register and drives no SDA low.
- R2: On a write, the two bytes after the address (command, count) are each acknowledged, and their values affect no register.
- R3: Write data bytes go to registers 0, 1, 2, ... in arrival order, and each is acknowledged. Register i appears on `cfg_regs_o[8*i+7:8*i]`.
- R4: A STOP after any complete byte ends the write. Registers already written keep their new values, and the others keep their previous values.
- R5: On a read, the slave sends the count byte 06h first and then registers 0 to 5, most significant bit first. Bytes requested beyond the last register read as FFh.
- R6: When the host NACKs a read byte, the slave stops driving SDA until the next START or STOP. Further clocked bits read as 1.
- R7: Write data bytes beyond register 5 are acknowledged and discarded.
- R8: After reset, registers 0 to 5 hold 00h, 0Fh, FFh, FFh, 3Ch and A5h, and SDA is not driven.
- R9: A pulse on SCL or SDA that lasts fewer than 3 system clocks is ignored.
- R10: The SDA drive enable changes only while the filtered SCL is low, except that START and STOP release it. The acknowledge drive is released after the acknowledge clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 = pull SDA low |
| cfg_regs_o | output | 48 | Register bank, register i at bits 8i+7:8i |

## Verification
The hardest situations to reach are those where the host leaves the normal transfer sequence. These are a STOP after a partial write, a NACK in the middle of a read, and a write that runs past the last register. In each case the slave must leave the registers and SDA in a consistent state. The directed tasks build these sequences bit by bit on a modelled open-drain bus, and the register outputs and the SDA level are compared afterwards. A glitch case inserts a two-cycle SCL pulse while SCL is low, in the middle of a byte, to show that the filter keeps the bit count intact.

// File: rtl/blkcfg_pkg.sv
package blkcfg_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_RX,
      PH_ACK_TX,
      PH_TX,
      PH_ACK_RX,
      PH_WAIT
   } ph_t;
   localparam int BYTE_W = 8;
endpackage

// File: rtl/blkcfg_sync_filt.sv
module blkcfg_sync_filt #(
   parameter int   STAGES   = 2,
   parameter int   FILT_LEN = 3,
   parameter logic IDLE_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic line_f
);
   localparam int CW = $clog2(FILT_LEN + 1);

   logic [STAGES-1:0] sync_q;
   logic [CW-1:0]     cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= {STAGES{IDLE_VAL}};
      else        sync_q <= {sync_q[STAGES-2:0], line_i};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_f <= IDLE_VAL;
         cnt_q  <= '0;
      end else if (sync_q[STAGES-1] == line_f) begin
         cnt_q <= '0;
      end else if (cnt_q == CW'(FILT_LEN - 1)) begin
         line_f <= sync_q[STAGES-1];
         cnt_q  <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/blkcfg_bus_cond.sv
module blkcfg_bus_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_f,
   input  logic sda_f,
   output logic cond_start,
   output logic cond_stop,
   output logic scl_rise,
   output logic scl_fall
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_f;
         sda_q <= sda_f;
      end
   end

   assign cond_start = scl_q & scl_f & sda_q & ~sda_f;
   assign cond_stop  = scl_q & scl_f & ~sda_q & sda_f;
   assign scl_rise   = ~scl_q & scl_f;
   assign scl_fall   = scl_q & ~scl_f;
endmodule

// File: rtl/blkcfg_proto.sv
module blkcfg_proto
   import blkcfg_pkg::*;
#(
   parameter int         NUM_REGS = 6,
   parameter logic [6:0] DEV_ADDR = 7'h69,
   localparam int        IDX_W    = $clog2(NUM_REGS + 3)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cond_start,
   input  logic                       cond_stop,
   input  logic                       scl_rise,
   input  logic                       scl_fall,
   input  logic                       sda_f,
   input  logic [NUM_REGS*BYTE_W-1:0] rd_data,
   output logic                       sda_oe,
   output logic                       wr_en,
   output logic [IDX_W-1:0]           wr_idx,
   output logic [BYTE_W-1:0]          wr_data
);
   localparam logic [IDX_W-1:0] BYTE_SAT = IDX_W'(NUM_REGS + 2);

   ph_t               ph;
   logic [3:0]        bit_cnt;
   logic [7:0]        shreg;
   logic              is_addr, is_read, host_ack;
   logic [IDX_W-1:0]  byte_no;
   logic [7:0]        tx_cur;

   always_comb begin
      tx_cur = 8'hFF;
      if (byte_no == '0) begin
         tx_cur = 8'(NUM_REGS);
      end else begin
         for (int k = 0; k < NUM_REGS; k++)
            if (byte_no == IDX_W'(k + 1)) tx_cur = rd_data[k*BYTE_W +: BYTE_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph       <= PH_IDLE;
         bit_cnt  <= '0;
         shreg    <= '0;
         is_addr  <= 1'b0;
         is_read  <= 1'b0;
         host_ack <= 1'b0;
         byte_no  <= '0;
         sda_oe   <= 1'b0;
         wr_en    <= 1'b0;
         wr_idx   <= '0;
         wr_data  <= '0;
      end else begin
         wr_en <= 1'b0;
         if (cond_start) begin
            ph      <= PH_RX;
            bit_cnt <= '0;
            is_addr <= 1'b1;
            byte_no <= '0;
            sda_oe  <= 1'b0;
         end else if (cond_stop) begin
            ph     <= PH_IDLE;
            sda_oe <= 1'b0;
         end else begin
            unique case (ph)
               PH_RX: begin
                  if (scl_rise && bit_cnt < 4'd8) begin
                     shreg   <= {shreg[6:0], sda_f};
                     bit_cnt <= bit_cnt + 1'b1;
                  end else if (scl_fall && bit_cnt == 4'd8) begin
                     if (is_addr) begin
                        if (shreg[7:1] == DEV_ADDR) begin
                           sda_oe  <= 1'b1;
                           is_read <= shreg[0];
                           is_addr <= 1'b0;
                           ph      <= PH_ACK_TX;
                        end else begin
                           ph <= PH_WAIT;
                        end
                     end else begin
                        sda_oe <= 1'b1;
                        ph     <= PH_ACK_TX;
                        if (byte_no >= IDX_W'(2) && byte_no < BYTE_SAT) begin
                           wr_en   <= 1'b1;
                           wr_idx  <= byte_no - IDX_W'(2);
                           wr_data <= shreg;
                        end
                        if (byte_no != BYTE_SAT) byte_no <= byte_no + 1'b1;
                     end
                  end
               end
               PH_ACK_TX: begin
                  if (scl_fall) begin
                     bit_cnt <= '0;
                     if (is_read) begin
                        shreg  <= tx_cur;
                        sda_oe <= ~tx_cur[7];
                        ph     <= PH_TX;
                        if (byte_no != BYTE_SAT) byte_no <= byte_no + 1'b1;
                     end else begin
                        sda_oe <= 1'b0;
                        ph     <= PH_RX;
                     end
                  end
               end
               PH_TX: begin
                  if (scl_fall) begin
                     if (bit_cnt == 4'd7) begin
                        sda_oe <= 1'b0;
                        ph     <= PH_ACK_RX;
                     end else begin
                        sda_oe  <= ~shreg[6];
                        shreg   <= {shreg[6:0], 1'b1};
                        bit_cnt <= bit_cnt + 1'b1;
                     end
                  end
               end
               PH_ACK_RX: begin
                  if (scl_rise) host_ack <= ~sda_f;
                  if (scl_fall) begin
                     if (host_ack) begin
                        shreg   <= tx_cur;
                        sda_oe  <= ~tx_cur[7];
                        bit_cnt <= '0;
                        ph      <= PH_TX;
                        if (byte_no != BYTE_SAT) byte_no <= byte_no + 1'b1;
                     end else begin
                        sda_oe <= 1'b0;
                        ph     <= PH_WAIT;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/blkcfg_regbank.sv
module blkcfg_regbank
   import blkcfg_pkg::*;
#(
   parameter int                       NUM_REGS    = 6,
   parameter logic [NUM_REGS*8-1:0]    REG_DEFAULT = '0,
   localparam int                      IDX_W       = $clog2(NUM_REGS + 3)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [IDX_W-1:0]           wr_idx,
   input  logic [BYTE_W-1:0]          wr_data,
   output logic [NUM_REGS*BYTE_W-1:0] regs_o
);
   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            regs_o[g*BYTE_W +: BYTE_W] <= REG_DEFAULT[g*BYTE_W +: BYTE_W];
         else if (wr_en && wr_idx == IDX_W'(g))
            regs_o[g*BYTE_W +: BYTE_W] <= wr_data;
      end
   end
endmodule

// File: rtl/blkcfg_i2c_slave.sv
module blkcfg_i2c_slave
   import blkcfg_pkg::*;
#(
   parameter int                    NUM_REGS    = 6,
   parameter logic [6:0]            DEV_ADDR    = 7'h69,
   parameter int                    SYNC_STAGES = 2,
   parameter int                    FILT_LEN    = 3,
   parameter logic [NUM_REGS*8-1:0] REG_DEFAULT = 48'hA5_3C_FF_FF_0F_00
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       scl_i,
   input  logic                       sda_i,
   output logic                       sda_oe,
   output logic [NUM_REGS*BYTE_W-1:0] cfg_regs_o
);
   localparam int IDX_W = $clog2(NUM_REGS + 3);

   if (NUM_REGS < 1 || NUM_REGS > 250) begin : g_bad_regs
      $error("NUM_REGS out of range");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (FILT_LEN < 1) begin : g_bad_filt
      $error("FILT_LEN must be at least 1");
   end

   logic [1:0] raw_lines, filt_lines;
   logic       scl_f, sda_f;
   logic       cond_start, cond_stop, scl_rise, scl_fall;
   logic       wr_en;
   logic [IDX_W-1:0]  wr_idx;
   logic [BYTE_W-1:0] wr_data;

   assign raw_lines = {sda_i, scl_i};

   for (genvar l = 0; l < 2; l++) begin : g_line
      blkcfg_sync_filt #(
         .STAGES  (SYNC_STAGES),
         .FILT_LEN(FILT_LEN),
         .IDLE_VAL(1'b1)
      ) filt_i (
         .clk   (clk),
         .rst_n (rst_n),
         .line_i(raw_lines[l]),
         .line_f(filt_lines[l])
      );
   end

   assign scl_f = filt_lines[0];
   assign sda_f = filt_lines[1];

   blkcfg_bus_cond cond_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_f     (scl_f),
      .sda_f     (sda_f),
      .cond_start(cond_start),
      .cond_stop (cond_stop),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall)
   );

   blkcfg_proto #(
      .NUM_REGS(NUM_REGS),
      .DEV_ADDR(DEV_ADDR)
   ) proto_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cond_start(cond_start),
      .cond_stop (cond_stop),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .sda_f     (sda_f),
      .rd_data   (cfg_regs_o),
      .sda_oe    (sda_oe),
      .wr_en     (wr_en),
      .wr_idx    (wr_idx),
      .wr_data   (wr_data)
   );

   blkcfg_regbank #(
      .NUM_REGS   (NUM_REGS),
      .REG_DEFAULT(REG_DEFAULT)
   ) bank_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_idx (wr_idx),
      .wr_data(wr_data),
      .regs_o (cfg_regs_o)
   );
endmodule

// File: rtl/blkcfg_chk.sv
module blkcfg_chk #(
   parameter int NUM_REGS = 6
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  scl_f,
   input logic                  cond_start,
   input logic                  cond_stop,
   input logic                  sda_oe,
   input logic [NUM_REGS*8-1:0] cfg_regs_o
);
   // R10: drive enable moves only while filtered SCL is low, or on START/STOP
   a_r10_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> (!$past(scl_f) || $past(cond_start) || $past(cond_stop)));

   // R10: STOP leaves SDA released
   a_r10_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cond_stop) |-> !sda_oe);

   // R1: a new START releases SDA while the address is received
   a_r1_start_releases: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cond_start) |-> !sda_oe);

   // R3: a register only changes while the slave acknowledges the data byte
   a_r3_regs_change_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cfg_regs_o) |-> sda_oe);

   // R10: acknowledge drive never starts while SCL is high
   a_r10_rise_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !$past(scl_f));
endmodule

bind blkcfg_i2c_slave blkcfg_chk #(.NUM_REGS(NUM_REGS)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .scl_f     (scl_f),
   .cond_start(cond_start),
   .cond_stop (cond_stop),
   .sda_oe    (sda_oe),
   .cfg_regs_o(cfg_regs_o)
);

// File: tb/blkcfg_i2c_slave_tb.sv
module blkcfg_i2c_slave_tb_top;
   localparam int Q = 25;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl_h = 1'b1;
   logic        sda_h = 1'b1;
   logic        sda_oe;
   logic [47:0] cfg_regs_o;
   logic        sda_line;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;
   logic [7:0] model [6];

   assign sda_line = sda_h & ~sda_oe;

   always #2.5 clk = ~clk;

   blkcfg_i2c_slave dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_h),
      .sda_i     (sda_line),
      .sda_oe    (sda_oe),
      .cfg_regs_o(cfg_regs_o)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wq(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_h = 1'b1; scl_h = 1'b1; wq(Q);
      sda_h = 1'b0; wq(Q);
      scl_h = 1'b0; wq(Q);
   endtask

   task automatic bus_stop();
      sda_h = 1'b0; wq(Q);
      scl_h = 1'b1; wq(Q);
      sda_h = 1'b1; wq(2*Q);
   endtask

   task automatic put_byte(input logic [7:0] b, input bit glitch, output bit acked);
      for (int i = 7; i >= 0; i--) begin
         sda_h = b[i]; wq(Q);
         if (glitch && i == 4) begin
            scl_h = 1'b1; wq(2); scl_h = 1'b0; wq(2);
         end
         scl_h = 1'b1; wq(2*Q);
         scl_h = 1'b0; wq(Q);
      end
      sda_h = 1'b1; wq(Q);
      scl_h = 1'b1; wq(Q);
      acked = ~sda_line;
      wq(Q);
      scl_h = 1'b0; wq(Q);
   endtask

   task automatic get_byte(input bit ack, output logic [7:0] b);
      sda_h = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         wq(Q); scl_h = 1'b1; wq(Q);
         b[i] = sda_line;
         wq(Q); scl_h = 1'b0;
      end
      wq(Q);
      sda_h = ~ack; wq(Q);
      scl_h = 1'b1; wq(2*Q);
      scl_h = 1'b0; wq(Q);
      sda_h = 1'b1;
   endtask

   task automatic cmp_regs(input string req);
      for (int i = 0; i < 6; i++)
         chk(req, cfg_regs_o[8*i +: 8], model[i]);
   endtask

   task automatic do_write(input string req, input int n, input logic [7:0] base, input bit glitch);
      bit a;
      bus_start();
      put_byte(8'hD2, 1'b0, a); chk({req, " R1 addr ack"}, a, 1);
      put_byte(8'h55, 1'b0, a); chk({req, " R2 cmd ack"}, a, 1);
      put_byte(8'h03, 1'b0, a); chk({req, " R2 count ack"}, a, 1);
      for (int i = 0; i < n; i++) begin
         put_byte(base + 8'(i * 17), glitch && i == 1, a);
         chk({req, " R3 data ack"}, a, 1);
         if (i < 6) model[i] = base + 8'(i * 17);
      end
      bus_stop();
   endtask

   task automatic t_reset();
      model = '{8'h00, 8'h0F, 8'hFF, 8'hFF, 8'h3C, 8'hA5};
      cmp_regs("R8 defaults");
      chk("R8 sda released", sda_oe, 0);
   endtask

   task automatic t_full_write();
      do_write("R3 full", 6, 8'h11, 1'b0);
      cmp_regs("R3 R2 full write");
   endtask

   task automatic t_partial_write();
      do_write("R4 partial", 3, 8'h80, 1'b0);
      cmp_regs("R4 partial write");
   endtask

   task automatic t_foreign_addr();
      bit a;
      bus_start();
      put_byte(8'hA4, 1'b0, a); chk("R1 foreign addr nack", a, 0);
      put_byte(8'h00, 1'b0, a); chk("R1 foreign data nack", a, 0);
      put_byte(8'h00, 1'b0, a); chk("R1 foreign data nack", a, 0);
      put_byte(8'h77, 1'b0, a); chk("R1 foreign data nack", a, 0);
      bus_stop();
      cmp_regs("R1 foreign no effect");
   endtask

   task automatic t_overflow();
      do_write("R7 overflow", 8, 8'h21, 1'b0);
      cmp_regs("R7 overflow regs");
   endtask

   task automatic t_read_all();
      bit a;
      logic [7:0] b;
      bus_start();
      put_byte(8'hD3, 1'b0, a); chk("R1 read addr ack", a, 1);
      get_byte(1'b1, b); chk("R5 count", b, 8'h06);
      for (int i = 0; i < 6; i++) begin
         get_byte(1'b1, b); chk("R5 reg data", b, model[i]);
      end
      get_byte(1'b0, b); chk("R5 beyond last", b, 8'hFF);
      bus_stop();
   endtask

   task automatic t_read_nack();
      bit a;
      logic [7:0] b;
      bus_start();
      put_byte(8'hD3, 1'b0, a); chk("R6 addr ack", a, 1);
      get_byte(1'b1, b); chk("R6 count", b, 8'h06);
      get_byte(1'b0, b); chk("R6 reg0", b, model[0]);
      get_byte(1'b0, b); chk("R6 released after nack", b, 8'hFF);
      bus_stop();
      chk("R6 idle release", sda_oe, 0);
   endtask

   task automatic t_glitch();
      do_write("R9 glitch", 6, 8'h5A, 1'b1);
      cmp_regs("R9 glitch filtered");
   endtask

   initial begin
      wq(10);
      rst_n = 1'b1;
      wq(10);
      t_reset();
      t_full_write();
      t_read_all();
      t_partial_write();
      t_read_all();
      t_foreign_addr();
      t_overflow();
      t_read_nack();
      t_glitch();
      t_read_all();
      chk("R10 final release", sda_oe, 0);
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule